// File: doc/BRIEF.md
# Hot-Swap Card Power Sequencer

This controller decides when an add-in card that has been pushed into a live host may take power. Two active-low presence contacts sit at opposite corners of the connector. The card is taken as seated only after both contacts have read low for an unbroken debounce window. The controller then waits for the host's power-enable input. It also checks the host-side supply flags, and a select input decides which of those flags count. Once these conditions hold, it turns on both gate-drive enables together and drives the active-low drive-enable output at the same moment.

With the gates on, the controller watches the card-side supply flags and a handshake that reports the card resets as released. Only when both are good does it assert the active-low signals-valid output. The host may then treat the bus interface as live. If the card is pulled, the host drops power-enable, or a host supply falls below trip, the shutdown runs in a fixed order. The gates go off first, signals-valid follows after a set number of cycles, and drive-enable is released last. The controller then goes back to idle and must see a fresh, complete debounce window before it powers the card again.

All pins are plain level signals, and none carries a data stream, so there is no valid/ready handshake and no back-pressure. The comparators that produce the supply flags, the gate slew control and the FET drive lie outside the block.

Top module: `hotswap_seq`

## Requirements
- R1: While reset is held and directly after it, both gate enables are 0 and drive_en_n and sig_valid_n are 1.
- R2: The card counts as seated only after present_a_n and present_b_n have both been 0 for DEB_TICKS ticks in a row, with one tick every PRESCALE clocks. A 1 on either pin during the window restarts the count. Gates can rise only after a cycle in which both pins were 0.
- R3: While host_pwr_en is 0, the gates stay off, or are turned off.
- R4: With sel_3v3_only at 0, both host5_ok and host3_ok must be 1 for the gates to turn on, and both card5_ok and card3_ok must be 1 for signals-valid. With sel_3v3_only at 1, the 5 V flags are ignored.
- R5: gate5_en and gate3_en always carry the same value, and drive_en_n is 0 whenever they are 1.
- R6: sig_valid_n goes to 0 only while the gates are on, the card supplies are good and resets_released is 1. If the card supplies or the handshake are lost, sig_valid_n returns to 1 and the gates stay on.
- R7: If a counted host supply flag is 0 while the gates are on, the gates are off after the next clock edge.
- R8: If either presence pin reads 1 while the gates are on, the gates are off after the next clock edge.
- R9: Once the gates turn off in a shutdown, sig_valid_n (if it was asserted) returns to 1 exactly SV_CYC cycles later, and drive_en_n returns to 1 exactly DE_CYC cycles later.
- R10: After a shutdown, the debounce count starts again from zero. The card is not powered again until a full new window has passed, even if the pins stayed low throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| present_a_n | input | 1 | Corner presence contact A, low when mated |
| present_b_n | input | 1 | Corner presence contact B, low when mated |
| host_pwr_en | input | 1 | Host permission to power the card, active high |
| sel_3v3_only | input | 1 | 1: only 3.3 V rails count; 0: 5 V and 3.3 V rails count |
| host5_ok | input | 1 | Host 5 V above trip |
| host3_ok | input | 1 | Host 3.3 V above trip |
| card5_ok | input | 1 | Card 5 V above trip |
| card3_ok | input | 1 | Card 3.3 V above trip |
| resets_released | input | 1 | Card reset outputs have been released |
| gate5_en | output | 1 | Turn on 5 V FET gate drive |
| gate3_en | output | 1 | Turn on 3.3 V FET gate drive |
| drive_en_n | output | 1 | Drive enable, active low |
| sig_valid_n | output | 1 | Signals valid, active low |

## Verification
The assertions check on every cycle that the two gates move together with drive-enable, that a supply loss, a power-enable drop or a removal removes the gates one edge later, and that the gates rise only after a cycle in which insertion was qualified. They also check that signals-valid asserts only over good card rails and a released reset, and that drive-enable is released only after signals-valid and the gates. The exact debounce window length, the restart of the window by a glitch, the SV_CYC and DE_CYC spacing of the shutdown steps, and the fresh window required after a shutdown depend on counting across many cycles. Only the bench's timed scenarios show these.

// File: rtl/hsw_pkg.sv
package hsw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_ARMED   = 3'd1,
    ST_POWERED = 3'd2,
    ST_VALID   = 3'd3,
    ST_SHUT    = 3'd4
  } hsw_state_t;
endpackage

// File: rtl/hsw_debounce.sv
// Qualifies insertion: both contacts low for DEB_TICKS prescaled ticks.
module hsw_debounce #(
  parameter int PRESCALE  = 50000,
  parameter int DEB_TICKS = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic pin_a_n,
  input  logic pin_b_n,
  output logic seated
);
  localparam int PW = $clog2(PRESCALE + 1);
  localparam int TW = $clog2(DEB_TICKS + 1);
  localparam logic [PW-1:0] P_LAST = PW'(PRESCALE - 1);
  localparam logic [TW-1:0] T_FULL = TW'(DEB_TICKS);

  logic [PW-1:0] pre_cnt;
  logic [TW-1:0] tick_cnt;
  logic          both_low;

  assign both_low = !pin_a_n && !pin_b_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt  <= '0;
      tick_cnt <= '0;
    end else if (clear || !both_low) begin
      pre_cnt  <= '0;
      tick_cnt <= '0;
    end else if (tick_cnt != T_FULL) begin
      if (pre_cnt == P_LAST) begin
        pre_cnt  <= '0;
        tick_cnt <= tick_cnt + 1'b1;
      end else begin
        pre_cnt <= pre_cnt + 1'b1;
      end
    end
  end

  assign seated = (tick_cnt == T_FULL);
endmodule

// File: rtl/hsw_supply_qual.sv
// Combines a 5 V / 3.3 V flag pair according to the rail selection.
module hsw_supply_qual (
  input  logic rail5_ok,
  input  logic rail3_ok,
  input  logic only_3v3,
  output logic good
);
  assign good = rail3_ok && (only_3v3 || rail5_ok);
endmodule

// File: rtl/hsw_shutdown_timer.sv
// Counts cycles spent in shutdown; gives the signals-valid hold and the exit.
module hsw_shutdown_timer #(
  parameter int SV_CYC = 250,
  parameter int DE_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic sv_hold,
  output logic done
);
  localparam int CW = $clog2(DE_CYC + 1);
  localparam logic [CW-1:0] SV_LIM  = CW'(SV_CYC);
  localparam logic [CW-1:0] DE_LAST = CW'(DE_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (active) cnt <= cnt + 1'b1;
    else             cnt <= '0;
  end

  assign sv_hold = active && (cnt < SV_LIM);
  assign done    = active && (cnt == DE_LAST);
endmodule

// File: rtl/hotswap_seq.sv
module hotswap_seq #(
  parameter int PRESCALE  = 50000,
  parameter int DEB_TICKS = 300,
  parameter int SV_CYC    = 250,
  parameter int DE_CYC    = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic present_a_n,
  input  logic present_b_n,
  input  logic host_pwr_en,
  input  logic sel_3v3_only,
  input  logic host5_ok,
  input  logic host3_ok,
  input  logic card5_ok,
  input  logic card3_ok,
  input  logic resets_released,
  output logic gate5_en,
  output logic gate3_en,
  output logic drive_en_n,
  output logic sig_valid_n
);
  import hsw_pkg::*;

  hsw_state_t state, state_nx;
  logic seated, host_good, card_good, shut_sv_hold, shut_done;
  logic removed, fault, card_ready, gates_on, was_valid;

  hsw_debounce #(.PRESCALE(PRESCALE), .DEB_TICKS(DEB_TICKS)) u_deb (
    .clk(clk), .rst_n(rst_n), .clear(state == ST_SHUT),
    .pin_a_n(present_a_n), .pin_b_n(present_b_n), .seated(seated)
  );

  hsw_supply_qual u_host_q (
    .rail5_ok(host5_ok), .rail3_ok(host3_ok),
    .only_3v3(sel_3v3_only), .good(host_good)
  );

  hsw_supply_qual u_card_q (
    .rail5_ok(card5_ok), .rail3_ok(card3_ok),
    .only_3v3(sel_3v3_only), .good(card_good)
  );

  hsw_shutdown_timer #(.SV_CYC(SV_CYC), .DE_CYC(DE_CYC)) u_shut (
    .clk(clk), .rst_n(rst_n), .active(state == ST_SHUT),
    .sv_hold(shut_sv_hold), .done(shut_done)
  );

  assign removed    = present_a_n || present_b_n;
  assign fault      = removed || !host_pwr_en || !host_good;
  assign card_ready = card_good && resets_released;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:    if (seated) state_nx = ST_ARMED;
      ST_ARMED:   if (removed) state_nx = ST_IDLE;
                  else if (host_pwr_en && host_good) state_nx = ST_POWERED;
      ST_POWERED: if (fault) state_nx = ST_SHUT;
                  else if (card_ready) state_nx = ST_VALID;
      ST_VALID:   if (fault) state_nx = ST_SHUT;
                  else if (!card_ready) state_nx = ST_POWERED;
      ST_SHUT:    if (shut_done) state_nx = ST_IDLE;
      default:    state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      was_valid <= 1'b0;
    end else begin
      state <= state_nx;
      if (state == ST_VALID)     was_valid <= 1'b1;
      else if (state != ST_SHUT) was_valid <= 1'b0;
    end
  end

  assign gates_on    = (state == ST_POWERED) || (state == ST_VALID);
  assign gate5_en    = gates_on;
  assign gate3_en    = gates_on;
  assign drive_en_n  = !(gates_on || state == ST_SHUT);
  assign sig_valid_n = !((state == ST_VALID) ||
                         (state == ST_SHUT && was_valid && shut_sv_hold));
endmodule

// File: rtl/hsw_seq_chk.sv
module hsw_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic present_a_n,
  input logic present_b_n,
  input logic host_pwr_en,
  input logic sel_3v3_only,
  input logic host5_ok,
  input logic host3_ok,
  input logic card3_ok,
  input logic resets_released,
  input logic gate5_en,
  input logic gate3_en,
  input logic drive_en_n,
  input logic sig_valid_n
);
  p_gates_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    gate5_en == gate3_en);

  p_gate_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    gate5_en |-> !drive_en_n);

  p_gate_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate5_en) |-> $past(!present_a_n && !present_b_n && host_pwr_en));

  p_hold_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate5_en && !host_pwr_en) |=> !gate5_en);

  p_pwr_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (gate5_en && !host_pwr_en) |=> !gate5_en);

  p_rail5_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gate5_en && !sel_3v3_only && !host5_ok) |=> !gate5_en);

  p_sv_card_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sig_valid_n) |-> $past(gate5_en && card3_ok && resets_released));

  p_host_loss_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (gate5_en && !host3_ok) |=> !gate5_en);

  p_removal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (gate5_en && (present_a_n || present_b_n)) |=> !gate5_en);

  p_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_en_n) |-> (sig_valid_n && !gate5_en));
endmodule

bind hotswap_seq hsw_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .present_a_n(present_a_n), .present_b_n(present_b_n),
  .host_pwr_en(host_pwr_en), .sel_3v3_only(sel_3v3_only), .host5_ok(host5_ok),
  .host3_ok(host3_ok), .card3_ok(card3_ok), .resets_released(resets_released),
  .gate5_en(gate5_en), .gate3_en(gate3_en), .drive_en_n(drive_en_n),
  .sig_valid_n(sig_valid_n)
);

// File: tb/hotswap_seq_test.sv
`timescale 1ns/1ps
module hotswap_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pa, pb, hpe, sel, h5, h3, c5, c3, rr;
  logic g5, g3, den, svn;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hotswap_seq #(.PRESCALE(2), .DEB_TICKS(4), .SV_CYC(3), .DE_CYC(7)) uut (
    .clk(clk), .rst_n(rst_n), .present_a_n(pa), .present_b_n(pb),
    .host_pwr_en(hpe), .sel_3v3_only(sel), .host5_ok(h5), .host3_ok(h3),
    .card5_ok(c5), .card3_ok(c3), .resets_released(rr),
    .gate5_en(g5), .gate3_en(g3), .drive_en_n(den), .sig_valid_n(svn)
  );

  // inputs {pa,pb,hpe,sel,h5,h3,c5,c3,rr}, wait cycles, expected {g5,g3,den,svn}
  localparam logic [16:0] VEC [9] = '{
    {9'b11_1_0_11_11_0, 4'd4,  4'b0011},
    {9'b00_1_0_11_11_0, 4'd4,  4'b0011},
    {9'b10_1_0_11_11_0, 4'd1,  4'b0011},
    {9'b00_0_0_11_11_0, 4'd12, 4'b0011},
    {9'b00_1_0_01_11_0, 4'd3,  4'b0011},
    {9'b00_1_1_01_01_0, 4'd2,  4'b1101},
    {9'b00_1_1_01_01_1, 4'd2,  4'b1100},
    {9'b00_1_1_01_00_1, 4'd2,  4'b1101},
    {9'b00_1_1_01_01_1, 4'd2,  4'b1100}
  };
  string vtag [9] = '{"R1 idle", "R2 short window", "R2 glitch restart",
                      "R3 held by power enable", "R4 5V host rail counted",
                      "R5 gates on", "R6 valid, 5V card ignored",
                      "R6 card rail lost", "R6 valid again"};

  task automatic chk(input string tag, input logic [3:0] exp);
    logic [3:0] act;
    act = {g5, g3, den, svn};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    {pa, pb, hpe, sel, h5, h3, c5, c3, rr} = 9'b11_1_0_11_11_0;
    repeat (3) @(negedge clk);
    chk("R1 in reset", 4'b0011);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", 4'b0011);

    for (int i = 0; i < 9; i++) begin
      {pa, pb, hpe, sel, h5, h3, c5, c3, rr} = VEC[i][16:8];
      repeat (int'(VEC[i][7:4])) @(negedge clk);
      chk(vtag[i], VEC[i][3:0]);
    end

    // R7 / R9: host 3.3 V loss from the valid state
    h3 = 1'b0;
    @(negedge clk);      chk("R7 gates off next edge", 4'b0000);
    repeat (2) @(negedge clk); chk("R9 sv still held", 4'b0000);
    @(negedge clk);      chk("R9 sv released at SV_CYC", 4'b0001);
    repeat (3) @(negedge clk); chk("R9 drive still held", 4'b0001);
    @(negedge clk);      chk("R9 drive released at DE_CYC", 4'b0011);
    h3 = 1'b1;
    // R10: pins never left low, a full new window is still needed
    repeat (6) @(negedge clk); chk("R10 no early restart", 4'b0011);
    repeat (6) @(negedge clk); chk("R10 restart after window", 4'b1100);

    // R8: removal
    pb = 1'b1;
    @(negedge clk);      chk("R8 removal gates off", 4'b0000);
    repeat (8) @(negedge clk); chk("R8 shutdown complete", 4'b0011);
    pb = 1'b0;
    repeat (14) @(negedge clk); chk("R2 reinsert powers", 4'b1100);

    // R3: power enable dropped while valid
    hpe = 1'b0;
    @(negedge clk);      chk("R3 power enable drop", 4'b0000);
    repeat (8) @(negedge clk); chk("R3 shutdown complete", 4'b0011);
    repeat (14) @(negedge clk); chk("R3 held while armed", 4'b0011);

    // R4: both 5 V rails counted when sel is 0
    sel = 1'b0; h5 = 1'b0; hpe = 1'b1;
    repeat (3) @(negedge clk); chk("R4 host 5V low blocks", 4'b0011);
    h5 = 1'b1;
    repeat (2) @(negedge clk); chk("R4 card 5V low blocks valid", 4'b1101);
    c5 = 1'b1;
    repeat (2) @(negedge clk); chk("R4 all rails valid", 4'b1100);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule